// File: doc/BRIEF.md
# Round-Robin Event Flag Scanner

This block arbitrates service requests coming from a multi-line terminal multiplexer. Every line owns four event flags, one per event type (receive, transmit, carrier on, carrier off). Each flag is raised by a single-cycle set pulse and stays set until the host services it. A scanner walks the flags in circular order, one position per clock. It stops on the first flag it finds set, locks, and raises the interrupt request that belongs to that flag's event type.

The host answers the interrupt with a read strobe. While the scanner is locked, the line number of the flagged event is presented on `svc_line`. The read clears the serviced flag, drops the request, unlocks the scanner and starts the next search from the position after the one just serviced. Because every search resumes where the previous one stopped, no line can starve the others. The number of lines is a parameter and must be a power of two. The default is 32 lines, which gives 128 flags and a 7-bit scan index.

Top module: `flag_scanner`

## Requirements
- R1: After reset, `irq` is 0, `scan_idx` is 0, `busy` is 0, and every flag is cleared. A flag set just before reset never produces a request.
- R2: Flag index p = line*4 + type, with type 0 receive, 1 transmit, 2 carrier on and 3 carrier off. A flag found at index p drives `irq` to the one-hot value with only bit (p mod 4) set.
- R3: A search checks positions `scan_idx`+1, +2, ... modulo the flag count, one position per clock, with `busy` high while it runs. From idle, a flag pulsed at distance d (1..128) ahead of `scan_idx` shows up on `irq` d+1 cycles after the edge that captured the pulse.
- R4: While locked (`irq` nonzero), `scan_idx` and `irq` hold, `busy` stays low, and newly set flags start no search. Those flags are kept and are found by later searches.
- R5: While locked, `svc_line` equals `scan_idx` >> 2. A read while locked clears that flag, drops `irq` and raises `busy` at the next edge. A flag at distance d is then reported d cycles after the read edge.
- R6: A read strobe while the scanner is not locked has no effect on `irq`, `scan_idx` or `busy`.
- R7: If the serviced flag gets a set pulse in the same cycle as the read, the flag stays set. It is found again after a full circuit of 128 positions.
- R8: A search checks at most 128 positions. If it finds nothing, `busy` falls 128 cycles after it started and `scan_idx` is back at its starting value.
- R9: At most one bit of `irq` is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_set | input | LINES*4 | One set pulse per flag; bit p sets flag p = line*4 + type |
| rd_strobe | input | 1 | Host read of the scanner |
| irq | output | 4 | Interrupt requests, one per event type |
| scan_idx | output | log2(LINES*4) | Current scan position |
| svc_line | output | log2(LINES) | Line number of the flag at the scan position |
| busy | output | 1 | High while a search is running |

## Verification
A wrong flag or lock state shows up at the ports within one circuit of the scanner. A lost flag means a request that never arrives. A flag that fails to clear means the same index is reported again after exactly 128 cycles. A stale lock means `scan_idx` freezes, or a read fails to drop `irq` at the next edge. A wrong search pointer shows up as an off-by-one latency between the pulse and the request, so the bench measures that latency exactly for each distance. This covers wrap-around, the full-circuit set-wins case, and four types on one line found on consecutive cycles.

// File: rtl/flag_scanner.sv
module flag_scanner #(
  parameter int LINES = 32,
  localparam int NFLAG = LINES * 4,
  localparam int IW = $clog2(NFLAG),
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flag_set,
  input  logic             rd_strobe,
  output logic [3:0]       irq,
  output logic [IW-1:0]    scan_idx,
  output logic [LW-1:0]    svc_line,
  output logic             busy
);

  logic [NFLAG-1:0] flags;
  logic [IW-1:0]    cnt;
  logic             locked;
  logic             svc_rd;
  logic [IW-1:0]    nxt;
  logic [NFLAG-1:0] clr_mask;

  assign svc_rd   = rd_strobe & locked;
  assign nxt      = scan_idx + 1'b1;
  assign clr_mask = svc_rd ? (NFLAG'(1) << scan_idx) : '0;
  assign svc_line = scan_idx[IW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_idx <= '0;
      cnt      <= '0;
      locked   <= 1'b0;
      busy     <= 1'b0;
      irq      <= '0;
    end else if (svc_rd) begin
      locked <= 1'b0;
      irq    <= '0;
      busy   <= 1'b1;
      cnt    <= '0;
    end else if (busy) begin
      scan_idx <= nxt;
      if (flags[nxt]) begin
        locked <= 1'b1;
        busy   <= 1'b0;
        irq    <= 4'b0001 << nxt[1:0];
      end else if (cnt == IW'(NFLAG - 1)) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (!locked && |flags) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

endmodule

// File: rtl/flag_scanner_chk.sv
module flag_scanner_chk #(
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_strobe,
  input logic [3:0]    irq,
  input logic [IW-1:0] scan_idx,
  input logic          busy
);

  // R9
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  // R2
  irq_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != 4'b0) |-> (irq == (4'b0001 << scan_idx[1:0])));

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != 4'b0 && !rd_strobe) |=> ($stable(scan_idx) && $stable(irq) && !busy));

  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != 4'b0 && rd_strobe) |=> (irq == 4'b0 && busy));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (scan_idx == IW'($past(scan_idx) + 1'b1)));

  // R3
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && irq != 4'b0));

  // R6
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == 4'b0 && !busy && rd_strobe) |=> (irq == 4'b0 && $stable(scan_idx)));

endmodule

bind flag_scanner flag_scanner_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
  .irq(irq), .scan_idx(scan_idx), .busy(busy)
);

// File: tb/tb_flag_scanner.sv
module tb_flag_scanner;
  localparam int LINES = 32;
  localparam int NF = LINES * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] flag_set = '0;
  logic          rd_strobe = 1'b0;
  logic [3:0]    irq;
  logic [6:0]    scan_idx;
  logic [4:0]    svc_line;
  logic          busy;

  int checks = 0;
  int errors = 0;

  flag_scanner #(.LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .rd_strobe(rd_strobe),
    .irq(irq), .scan_idx(scan_idx), .svc_line(svc_line), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [NF-1:0] m);
    @(negedge clk) flag_set = m;
    @(negedge clk) flag_set = '0;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (irq == 4'b0 && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_read(input int exp_line, input string req);
    @(negedge clk);
    chk(svc_line == 5'(exp_line), req, svc_line, exp_line);
    rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  function automatic logic [NF-1:0] bitp(input int p);
    return NF'(1) << p;
  endfunction

  task automatic t_reset;
    chk(irq == 0, "R1 irq", irq, 0);
    chk(scan_idx == 0, "R1 idx", scan_idx, 0);
    chk(busy == 0, "R1 busy", busy, 0);
  endtask

  task automatic t_basic_and_lock;
    int c;
    pulse(bitp(6));
    wait_irq(c);
    chk(c == 7, "R3 latency idle", c, 7);
    chk(irq == 4'b0100, "R2 carrier-on irq", irq, 4);
    chk(scan_idx == 6, "R3 idx", scan_idx, 6);
    pulse(bitp(20));
    repeat (10) @(negedge clk);
    chk(scan_idx == 6, "R4 idx held", scan_idx, 6);
    chk(irq == 4'b0100, "R4 irq held", irq, 4);
    chk(busy == 0, "R4 no search", busy, 0);
    do_read(1, "R5 line");
    chk(irq == 0, "R5 irq dropped", irq, 0);
    chk(busy == 1, "R5 search restarts", busy, 1);
    wait_irq(c);
    chk(c == 14, "R5 latency after read", c, 14);
    chk(irq == 4'b0001, "R2 receive irq", irq, 1);
    chk(scan_idx == 20, "R4 kept flag found", scan_idx, 20);
  endtask

  task automatic t_empty_circuit;
    do_read(5, "R5 line 5");
    repeat (127) @(negedge clk);
    chk(busy == 1, "R8 busy still high", busy, 1);
    @(negedge clk);
    chk(busy == 0, "R8 busy ends", busy, 0);
    chk(scan_idx == 20, "R8 idx back", scan_idx, 20);
    chk(irq == 0, "R8 nothing found", irq, 0);
  endtask

  task automatic t_ignored_read;
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    chk(irq == 0, "R6 irq", irq, 0);
    chk(scan_idx == 20, "R6 idx", scan_idx, 20);
    chk(busy == 0, "R6 busy", busy, 0);
  endtask

  task automatic t_order_wrap;
    int c;
    pulse(bitp(3) | bitp(25) | bitp(127));
    wait_irq(c);
    chk(c == 6, "R3 first latency", c, 6);
    chk(irq == 4'b0010, "R2 transmit irq", irq, 2);
    chk(scan_idx == 25, "R3 first idx", scan_idx, 25);
    do_read(6, "R5 line 6");
    wait_irq(c);
    chk(c == 102, "R3 second latency", c, 102);
    chk(irq == 4'b1000, "R2 carrier-off irq", irq, 8);
    do_read(31, "R5 line 31");
    wait_irq(c);
    chk(c == 4, "R3 wrap latency", c, 4);
    chk(scan_idx == 3, "R3 wrap idx", scan_idx, 3);
  endtask

  task automatic t_set_wins;
    int c;
    @(negedge clk);
    rd_strobe = 1'b1;
    flag_set = bitp(3);
    @(negedge clk);
    rd_strobe = 1'b0;
    flag_set = '0;
    wait_irq(c);
    chk(c == 128, "R7 full circuit", c, 128);
    chk(scan_idx == 3, "R7 idx", scan_idx, 3);
    chk(irq == 4'b1000, "R7 irq", irq, 8);
    do_read(0, "R5 line 0");
    repeat (140) @(negedge clk);
    chk(irq == 0, "R5 flag cleared", irq, 0);
  endtask

  task automatic t_four_types;
    int c;
    pulse(bitp(40) | bitp(41) | bitp(42) | bitp(43));
    wait_irq(c);
    chk(c == 38, "R3 latency to 40", c, 38);
    for (int t = 0; t < 4; t++) begin
      if (t > 0) begin
        wait_irq(c);
        chk(c == 1, "R3 adjacent latency", c, 1);
      end
      chk(irq == (4'b0001 << t), "R2 type order", irq, 1 << t);
      do_read(10, "R5 line 10");
    end
    repeat (130) @(negedge clk);
  endtask

  task automatic t_reset_clears;
    @(negedge clk) flag_set = bitp(50);
    @(negedge clk) begin flag_set = '0; rst_n = 1'b0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    repeat (200) @(negedge clk);
    chk(irq == 0, "R1 flag cleared by reset", irq, 0);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic_and_lock;
    t_empty_circuit;
    t_ignored_read;
    t_order_wrap;
    t_set_wins;
    t_four_types;
    t_reset_clears;
    finish_up;
  end
endmodule